// File: doc/BRIEF.md
# Static Slot Schedule Broadcast Link Controller

This block is the link-side controller of one node attached to a shared broadcast line. A small schedule table, filled while the link is stopped, fixes for each of its entries whether the node transmits, receives or stays silent. It also fixes which word of the node's local data store is involved and how many base slots the entry stretches over. While running, the controller walks the entries in a fixed order and starts again from the first one after the last. Each pass through the table is one frame.

On a transmit entry the controller copies the addressed word into a shift register. It then drives the word onto the serial data lane most significant bit first. A strobe on a separate clock lane marks the first cycle of every bit. On a receive entry it shifts in the serial line bit by bit, taking one bit on every cycle in which the incoming clock lane is high. Once a full word has arrived, it writes the word into the data store. The data store has two ports: the compute side reads and writes it through its own port, and the controller's updates win when both sides write the same word in the same cycle.

A stretched entry holds every bit for span+1 cycles. This gives a channel that occupies several consecutive base slots at a proportionally lower bit rate.

Top module: `tdma_node_ctrl`

## Requirements
- R1: After reset, tx_en_o, tx_clk_o, tx_data_o and frame_o are 0. Every data-store word reads as 0, and every schedule entry is idle with span 0.
- R2: A schedule entry is the packed word {action[1:0], addr[ADDR_W-1:0], span[SPAN_W-1:0]}, where action 2'b00 is idle, 2'b01 is transmit, 2'b10 is receive and 2'b11 acts as idle. An entry is stored by tbl_we_i only while run_i is 0. A write made while run_i is 1 is ignored.
- R3: Starting from the first clock edge at which run_i is 1, entries 0 to N_ENTRY-1 run in order and then wrap to entry 0. Each entry takes one setup cycle followed by WORD_W*(span+1) bit cycles. Driving run_i to 0 stops the walk and returns it to entry 0.
- R4: frame_o is 1 exactly in the setup cycle of entry 0, and only then.
- R5: During the bit cycles of a transmit entry, tx_en_o is 1 and tx_data_o carries the data-store word at addr, most significant bit first, each bit held for span+1 cycles. At all other times tx_en_o and tx_data_o are 0.
- R6: tx_clk_o is 1 in the first cycle of each bit of a transmit entry and is 0 in every other cycle.
- R7: During the bit cycles of a receive entry, each cycle with rx_clk_i = 1 takes in rx_data_i, most significant bit first. The WORD_W-th bit taken writes the assembled word to addr. Further strobes in that entry are ignored.
- R8: rx_clk_i and rx_data_i have no effect during idle or transmit entries, during setup cycles, or while the walk is stopped.
- R9: A compute-port write stores cpu_wdata_i at cpu_addr_i. cpu_rdata_o returns the word at cpu_addr_i one cycle after the address is presented.
- R10: When the controller and the compute port write the same address in the same cycle, the controller's word is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | 1 walks the schedule, 0 stops it and allows table loading |
| tbl_we_i | input | 1 | Schedule entry write strobe |
| tbl_idx_i | input | IDX_W | Schedule entry index |
| tbl_entry_i | input | ENTRY_W | Packed entry {action, addr, span} |
| cpu_we_i | input | 1 | Compute-side write enable |
| cpu_addr_i | input | ADDR_W | Compute-side word address |
| cpu_wdata_i | input | WORD_W | Compute-side write data |
| cpu_rdata_o | output | WORD_W | Compute-side read data, one cycle latency |
| rx_data_i | input | 1 | Incoming serial data lane |
| rx_clk_i | input | 1 | Incoming bit strobe lane |
| tx_data_o | output | 1 | Outgoing serial data lane |
| tx_clk_o | output | 1 | Outgoing bit strobe lane |
| tx_en_o | output | 1 | Line driver enable, high while this node owns the slot |
| frame_o | output | 1 | Frame start marker |

## Verification
A wrong slot counter or entry index shifts every later transmission. It shows at the ports within one entry: tx_en_o rises in the wrong cycle, or frame_o misses its place 16 entries later. A shift register that is loaded or advanced wrongly corrupts the serial word seen on tx_data_o in that same entry. A wrong receive bit count or a wrong address decode does not show on the line at all. It shows only when the compute port later reads back a word that was not written, or that was overwritten. For this reason the bench reads back every receive target and every word that should have stayed unchanged.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_SEND = 2'd1,
        ACT_RECV = 2'd2,
        ACT_RSVD = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_BITS  = 2'd2
    } phase_e;

endpackage

// File: rtl/tdma_sched_table.sv
module tdma_sched_table #(
    parameter int N_ENTRY = 16,
    parameter int ENTRY_W = 8,
    localparam int IDX_W  = $clog2(N_ENTRY)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lock_i,
    input  logic               we_i,
    input  logic [IDX_W-1:0]   widx_i,
    input  logic [ENTRY_W-1:0] wentry_i,
    input  logic [IDX_W-1:0]   ridx_i,
    output logic [ENTRY_W-1:0] rentry_o
);

    typedef struct packed {
        logic [N_ENTRY-1:0][ENTRY_W-1:0] ent;
    } tbl_t;

    tbl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_i && !lock_i) begin
            s_d.ent[widx_i] = wentry_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rentry_o = s_q.ent[ridx_i];

    // R2
    tbl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> (s_q.ent == $past(s_q.ent)));

endmodule

// File: rtl/tdma_dpram.sv
module tdma_dpram #(
    parameter int WORD_W = 8,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [WORD_W-1:0] cpu_wdata_i,
    output logic [WORD_W-1:0] cpu_rdata_o,
    input  logic              ctl_we_i,
    input  logic [ADDR_W-1:0] ctl_addr_i,
    input  logic [WORD_W-1:0] ctl_wdata_i,
    output logic [WORD_W-1:0] ctl_rdata_o
);

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] mem;
        logic [WORD_W-1:0]            rdata;
    } ram_t;

    ram_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.rdata = s_q.mem[cpu_addr_i];
        if (cpu_we_i) begin
            s_d.mem[cpu_addr_i] = cpu_wdata_i;
        end
        // the link side is applied last so it overrides a same-address write
        if (ctl_we_i) begin
            s_d.mem[ctl_addr_i] = ctl_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cpu_rdata_o = s_q.rdata;
    assign ctl_rdata_o = s_q.mem[ctl_addr_i];

    // R10
    ctl_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we_i && cpu_we_i && (ctl_addr_i == cpu_addr_i))
        |=> (s_q.mem[$past(ctl_addr_i)] == $past(ctl_wdata_i)));

    // R9
    cpu_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we_i && !(ctl_we_i && (ctl_addr_i == cpu_addr_i)))
        |=> (s_q.mem[$past(cpu_addr_i)] == $past(cpu_wdata_i)));

endmodule

// File: rtl/tdma_sequencer.sv
module tdma_sequencer
    import tdma_pkg::*;
#(
    parameter int N_ENTRY = 16,
    parameter int WORD_W  = 8,
    parameter int SPAN_W  = 2,
    localparam int IDX_W  = $clog2(N_ENTRY),
    localparam int BIT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [SPAN_W-1:0] span_i,
    output phase_e            phase_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              bit_first_o,
    output logic              bit_last_o
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRY - 1);

    typedef struct packed {
        phase_e            ph;
        logic [IDX_W-1:0]  idx;
        logic [BIT_W-1:0]  bitn;
        logic [SPAN_W-1:0] sub;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!run_i) begin
            s_d = '{ph: PH_IDLE, idx: '0, bitn: '0, sub: '0};
        end else begin
            unique case (s_q.ph)
                PH_IDLE: begin
                    s_d.ph  = PH_SETUP;
                    s_d.idx = '0;
                end
                PH_SETUP: begin
                    s_d.ph   = PH_BITS;
                    s_d.bitn = '0;
                    s_d.sub  = '0;
                end
                PH_BITS: begin
                    if (s_q.sub == span_i) begin
                        s_d.sub = '0;
                        if (s_q.bitn == LAST_BIT) begin
                            s_d.ph   = PH_SETUP;
                            s_d.bitn = '0;
                            s_d.idx  = (s_q.idx == LAST_IDX) ? '0 : s_q.idx + 1'b1;
                        end else begin
                            s_d.bitn = s_q.bitn + 1'b1;
                        end
                    end else begin
                        s_d.sub = s_q.sub + 1'b1;
                    end
                end
                default: s_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, idx: '0, bitn: '0, sub: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o     = s_q.ph;
    assign idx_o       = s_q.idx;
    assign bit_first_o = (s_q.ph == PH_BITS) && (s_q.sub == '0);
    assign bit_last_o  = (s_q.ph == PH_BITS) && (s_q.sub == span_i);

    // R3
    setup_to_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_SETUP && run_i)
        |=> (s_q.ph == PH_BITS && s_q.bitn == '0 && s_q.sub == '0 && $stable(s_q.idx)));

    // R3
    sub_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_BITS && run_i && s_q.sub != span_i)
        |=> (s_q.sub == $past(s_q.sub) + 1'b1 && $stable(s_q.bitn)));

    // R3
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (s_q.ph == PH_IDLE && s_q.idx == '0));

endmodule

// File: rtl/tdma_shifter.sv
module tdma_shifter #(
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              setup_i,
    input  logic              send_i,
    input  logic              recv_i,
    input  logic              bit_last_i,
    input  logic [WORD_W-1:0] load_word_i,
    input  logic              rx_data_i,
    input  logic              rx_clk_i,
    output logic              tx_bit_o,
    output logic              wr_en_o,
    output logic [WORD_W-1:0] wr_word_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] tx_sh;
        logic [WORD_W-2:0] rx_sh;
        logic [CNT_W-1:0]  rx_cnt;
    } sh_t;

    sh_t  s_d, s_q;
    logic take;

    always_comb begin
        s_d     = s_q;
        take    = recv_i && rx_clk_i && (s_q.rx_cnt != FULL);
        wr_en_o = take && (s_q.rx_cnt == LAST);
        wr_word_o = {s_q.rx_sh, rx_data_i};
        if (setup_i) begin
            s_d.tx_sh  = load_word_i;
            s_d.rx_cnt = '0;
        end else begin
            if (send_i && bit_last_i) begin
                s_d.tx_sh = {s_q.tx_sh[WORD_W-2:0], 1'b0};
            end
            if (take) begin
                s_d.rx_sh  = {s_q.rx_sh[WORD_W-3:0], rx_data_i};
                s_d.rx_cnt = s_q.rx_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_bit_o = s_q.tx_sh[WORD_W-1];

    // R7
    rx_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rx_cnt <= FULL);

    // R7
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

endmodule

// File: rtl/tdma_node_ctrl.sv
module tdma_node_ctrl
    import tdma_pkg::*;
#(
    parameter int N_ENTRY  = 16,
    parameter int WORD_W   = 8,
    parameter int DB_DEPTH = 16,
    parameter int SPAN_W   = 2,
    localparam int IDX_W   = $clog2(N_ENTRY),
    localparam int ADDR_W  = $clog2(DB_DEPTH),
    localparam int ENTRY_W = 2 + ADDR_W + SPAN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               tbl_we_i,
    input  logic [IDX_W-1:0]   tbl_idx_i,
    input  logic [ENTRY_W-1:0] tbl_entry_i,
    input  logic               cpu_we_i,
    input  logic [ADDR_W-1:0]  cpu_addr_i,
    input  logic [WORD_W-1:0]  cpu_wdata_i,
    output logic [WORD_W-1:0]  cpu_rdata_o,
    input  logic               rx_data_i,
    input  logic               rx_clk_i,
    output logic               tx_data_o,
    output logic               tx_clk_o,
    output logic               tx_en_o,
    output logic               frame_o
);

    phase_e             phase;
    logic [IDX_W-1:0]   idx;
    logic               bit_first, bit_last;
    logic [ENTRY_W-1:0] entry;
    act_e               act;
    logic [ADDR_W-1:0]  e_addr;
    logic [SPAN_W-1:0]  e_span;
    logic               in_bits, is_send, is_recv;
    logic [WORD_W-1:0]  load_word, wr_word;
    logic               wr_en, tx_bit;

    tdma_sched_table #(.N_ENTRY(N_ENTRY), .ENTRY_W(ENTRY_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_i   (run_i),
        .we_i     (tbl_we_i),
        .widx_i   (tbl_idx_i),
        .wentry_i (tbl_entry_i),
        .ridx_i   (idx),
        .rentry_o (entry)
    );

    assign act    = act_e'(entry[ENTRY_W-1 -: 2]);
    assign e_addr = entry[SPAN_W +: ADDR_W];
    assign e_span = entry[SPAN_W-1:0];

    tdma_sequencer #(.N_ENTRY(N_ENTRY), .WORD_W(WORD_W), .SPAN_W(SPAN_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_i),
        .span_i      (e_span),
        .phase_o     (phase),
        .idx_o       (idx),
        .bit_first_o (bit_first),
        .bit_last_o  (bit_last)
    );

    assign in_bits = (phase == PH_BITS);
    assign is_send = in_bits && (act == ACT_SEND);
    assign is_recv = in_bits && (act == ACT_RECV);

    tdma_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .setup_i     (phase == PH_SETUP),
        .send_i      (is_send),
        .recv_i      (is_recv),
        .bit_last_i  (bit_last),
        .load_word_i (load_word),
        .rx_data_i   (rx_data_i),
        .rx_clk_i    (rx_clk_i),
        .tx_bit_o    (tx_bit),
        .wr_en_o     (wr_en),
        .wr_word_o   (wr_word)
    );

    tdma_dpram #(.WORD_W(WORD_W), .DEPTH(DB_DEPTH)) u_db (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_we_i    (cpu_we_i),
        .cpu_addr_i  (cpu_addr_i),
        .cpu_wdata_i (cpu_wdata_i),
        .cpu_rdata_o (cpu_rdata_o),
        .ctl_we_i    (wr_en),
        .ctl_addr_i  (e_addr),
        .ctl_wdata_i (wr_word),
        .ctl_rdata_o (load_word)
    );

    assign tx_en_o   = is_send;
    assign tx_clk_o  = is_send && bit_first;
    assign tx_data_o = is_send && tx_bit;
    assign frame_o   = (phase == PH_SETUP) && (idx == '0);

    // R6
    strobe_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clk_o |-> tx_en_o);

    // R4
    frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |=> !frame_o);

    // R5
    send_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en_o) |-> tx_clk_o);

    // R8
    no_write_outside_recv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (in_bits && act == ACT_RECV));

endmodule

// File: tb/tdma_node_ctrl_tb.sv
module tdma_node_ctrl_tb;

    localparam int W = 8;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       run_i = 0;
    logic       tbl_we_i = 0;
    logic [3:0] tbl_idx_i = 0;
    logic [7:0] tbl_entry_i = 0;
    logic       cpu_we_i = 0;
    logic [3:0] cpu_addr_i = 0;
    logic [7:0] cpu_wdata_i = 0;
    logic [7:0] cpu_rdata_o;
    logic       rx_data_i = 0;
    logic       rx_clk_i = 0;
    logic       tx_data_o, tx_clk_o, tx_en_o, frame_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    tdma_node_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .run_i(run_i),
        .tbl_we_i(tbl_we_i), .tbl_idx_i(tbl_idx_i), .tbl_entry_i(tbl_entry_i),
        .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
        .cpu_rdata_o(cpu_rdata_o), .rx_data_i(rx_data_i), .rx_clk_i(rx_clk_i),
        .tx_data_o(tx_data_o), .tx_clk_o(tx_clk_o), .tx_en_o(tx_en_o), .frame_o(frame_o)
    );

    // {action[1:0], addr[3:0], span[1:0], word[7:0]}; action 0 idle, 1 send, 2 receive
    localparam logic [15:0] VEC [16] = '{
        {2'd1, 4'd1,  2'd0, 8'hA5},
        {2'd2, 4'd8,  2'd0, 8'h3C},
        {2'd0, 4'd14, 2'd0, 8'h00},
        {2'd1, 4'd2,  2'd1, 8'h81},
        {2'd2, 4'd9,  2'd2, 8'h7E},
        {2'd1, 4'd3,  2'd3, 8'hC3},
        {2'd2, 4'd10, 2'd1, 8'h01},
        {2'd0, 4'd0,  2'd3, 8'h00},
        {2'd1, 4'd4,  2'd0, 8'hFF},
        {2'd2, 4'd11, 2'd0, 8'h80},
        {2'd1, 4'd5,  2'd2, 8'h00},
        {2'd2, 4'd13, 2'd3, 8'hE7},
        {2'd1, 4'd6,  2'd1, 8'h5A},
        {2'd0, 4'd0,  2'd0, 8'h00},
        {2'd2, 4'd15, 2'd0, 8'h96},
        {2'd1, 4'd7,  2'd0, 8'h69}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tbl_write(input logic [3:0] idx, input logic [7:0] ent);
        @(negedge clk);
        tbl_we_i = 1; tbl_idx_i = idx; tbl_entry_i = ent;
        @(negedge clk);
        tbl_we_i = 0;
    endtask

    task automatic cpu_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_we_i = 1; cpu_addr_i = a; cpu_wdata_i = d;
        @(negedge clk);
        cpu_we_i = 0;
    endtask

    task automatic cpu_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr_i = a;
        @(negedge clk);
        d = cpu_rdata_o;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!tx_en_o && !tx_clk_o && !tx_data_o && !frame_o, "R1 outputs", {tx_en_o, tx_clk_o, tx_data_o, frame_o}, 0);
        rst_n = 1;
        cpu_read(4'd9, rd);
        check(rd == 8'h00, "R1 store cleared", rd, 0);
        // R1: schedule cleared, so a short run transmits nothing
        @(negedge clk); run_i = 1;
        begin
            int seen = 0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (tx_en_o || tx_clk_o) seen++;
            end
            check(seen == 0, "R1 table idle", seen, 0);
        end
        run_i = 0;
        @(negedge clk);

        // load schedule (R2) and preload store (R9)
        for (int e = 0; e < 16; e++) begin
            tbl_write(4'(e), VEC[e][15:8]);
            if (VEC[e][15:14] == 2'd1) cpu_write(VEC[e][13:10], VEC[e][7:0]);
        end
        cpu_write(4'd14, 8'h5A);

        // walk one frame
        @(negedge clk); run_i = 1;
        for (int e = 0; e < 16; e++) begin
            logic [1:0] act;
            logic [1:0] span;
            logic [7:0] dat;
            logic [7:0] word;
            int perr;
            act = VEC[e][15:14]; span = VEC[e][9:8]; dat = VEC[e][7:0];
            word = 0; perr = 0;
            @(negedge clk);   // setup cycle
            rx_clk_i = 0; rx_data_i = 0;
            check(frame_o == (e == 0), "R4 frame marker", frame_o, (e == 0));
            if (tx_en_o || tx_clk_o) perr++;
            for (int b = 0; b < W; b++) begin
                for (int s = 0; s <= int'(span); s++) begin
                    @(negedge clk);
                    if (frame_o) perr++;
                    if (act == 2'd1) begin
                        if (!tx_en_o) perr++;
                        if (tx_clk_o != (s == 0)) perr++;
                        if (tx_data_o != dat[W-1-b]) perr++;
                        if (s == 0) word = {word[6:0], tx_data_o};
                        rx_clk_i = 0;
                    end else begin
                        if (tx_en_o || tx_clk_o || tx_data_o) perr++;
                        if (act == 2'd2) begin
                            rx_clk_i = (s == 0); rx_data_i = dat[W-1-b];
                        end else begin
                            rx_clk_i = 1; rx_data_i = 1;   // R8: strobes in an idle entry
                        end
                    end
                end
            end
            check(perr == 0, "R3/R5/R6 slot timing", perr, 0);
            if (act == 2'd1) check(word == dat, "R5 serial word", word, dat);
        end
        // R3/R4: wrap to entry 0 right after the last entry
        @(negedge clk);
        rx_clk_i = 0; rx_data_i = 0;
        check(frame_o == 1'b1, "R4 wrap frame", frame_o, 1);
        // R2: table write while running is ignored (entry 1 to send)
        tbl_we_i = 1; tbl_idx_i = 4'd1; tbl_entry_i = {2'd1, 4'd8, 2'd0};
        @(negedge clk); tbl_we_i = 0;
        repeat (7) @(negedge clk);
        begin
            int seen = 0;
            for (int c = 0; c < 9; c++) begin
                @(negedge clk);
                if (tx_en_o) seen++;
            end
            check(seen == 0, "R2 locked table", seen, 0);
        end
        run_i = 0;
        @(negedge clk);

        // readback of receive targets (R7) and untouched words (R8, R9)
        for (int e = 0; e < 16; e++) begin
            if (VEC[e][15:14] == 2'd2) begin
                cpu_read(VEC[e][13:10], rd);
                check(rd == VEC[e][7:0], "R7 received word", rd, VEC[e][7:0]);
            end
        end
        cpu_read(4'd14, rd);
        check(rd == 8'h5A, "R8 idle entry ignores rx", rd, 8'h5A);
        cpu_read(4'd0, rd);
        check(rd == 8'h00, "R8 idle entry ignores rx", rd, 0);
        cpu_read(4'd3, rd);
        check(rd == 8'hC3, "R9 compute write", rd, 8'hC3);

        // R10 collision, plus R3 frame period of 16 entries of 9 cycles
        tbl_write(4'd0, {2'd2, 4'd12, 2'd0});
        for (int e = 1; e < 16; e++) tbl_write(4'(e), 8'h00);
        @(negedge clk); run_i = 1;
        @(negedge clk);
        check(frame_o == 1'b1, "R4 frame at start", frame_o, 1);
        for (int b = 0; b < W; b++) begin
            @(negedge clk);
            rx_clk_i = 1; rx_data_i = (8'hC6 >> (W - 1 - b)) & 1;
            if (b == W - 1) begin
                cpu_we_i = 1; cpu_addr_i = 4'd12; cpu_wdata_i = 8'h11;
            end
        end
        @(negedge clk);
        rx_clk_i = 0; cpu_we_i = 0;
        repeat (134) @(negedge clk);
        check(frame_o == 1'b0, "R3 no early frame", frame_o, 0);
        @(negedge clk);
        check(frame_o == 1'b1, "R3 frame period", frame_o, 1);
        run_i = 0;
        @(negedge clk);
        cpu_read(4'd12, rd);
        check(rd == 8'hC6, "R10 link write wins", rd, 8'hC6);
        // R8: rx strobes while stopped have no effect
        rx_clk_i = 1; rx_data_i = 1;
        repeat (10) @(negedge clk);
        rx_clk_i = 0;
        cpu_read(4'd12, rd);
        check(rd == 8'hC6, "R8 stopped ignores rx", rd, 8'hC6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule